// File: doc/BRIEF.md
# MAC Address Lookup Table

This block is a small station table for a three-port switch. Software fills the table one entry at a time through a register window. It stages an entry in three 32-bit data words, then writes an index to a table-control register, either to store the staged words into that slot or to load the slot into the words. Each entry is a type-tagged record. Its low 48 bits hold a MAC address. Its upper bits are read in one of two ways, chosen by the address's group bit: a unicast overlay (aging class, secure flag, blocked flag, port number) or a multicast overlay (forward state, per-port mask).

A lookup request carries a 48-bit destination address. The engine walks the table one slot per cycle from slot 0 and stops at the first slot that holds an address record with the same MAC. It then returns a hit flag, the multicast flag, the stored port number and a forward mask. The forward mask is filtered by a 2-bit state kept per port, so only ports in the forwarding state can appear in it. A control register enables the engine, starts a table wipe that takes one cycle per slot, and holds a VLAN-awareness mode bit.

Top module: `mac_lookup_table`

Register map (byte offsets on `reg_addr`): 0x00 control, 0x04 table control, 0x08 entry word high, 0x0C entry word middle, 0x10 entry word low, 0x14 + 4*p state of port p.

## Requirements
- R1: After reset every register reads 0, `lkp_ready` is high, and every table slot reads back as zero and never matches.
- R2: Writing the table-control register with bit 31 set stores {high, middle, low} into slot `wdata[IW-1:0]`. Writing it with bit 31 clear loads that slot into the three words. The word order is reversed: the high word (0x08) holds entry bits 68:64 in its bits 4:0, the middle word holds 63:32 and the low word holds 31:0.
- R3: A lookup is accepted on a clock edge where `lkp_valid` and `lkp_ready` are both high. Slots are examined from index 0 upward, one per cycle. Only entries of kind 1 (address) or 3 (VLAN+address) in bits 61:60 can match, never kind 0 (free) or kind 2 (VLAN), and the first one whose bits 47:0 equal the address wins. A hit in slot i raises `res_valid` for one cycle, i+1 edges after acceptance.
- R4: When no slot matches, `res_valid` rises DEPTH edges after acceptance with `res_hit` and `res_mask` both zero.
- R5: A hit with bit 40 clear is unicast. `res_port` is bits 67:66, and `res_mask` has only bit `res_port` set, provided that the port exists, blocked bit 65 is clear and that port's state is 3 (forwarding). Otherwise the mask is zero.
- R6: A hit with bit 40 set is multicast. `res_mcast` is high and `res_mask` is bits 68:66 ANDed with the set of ports whose state is 3.
- R7: The register at 0x14 + 4*p holds port p's state in bits 1:0 (0 disabled, 1 blocking, 2 learning, 3 forwarding) and reads it back.
- R8: With the engine disabled (control bit 0 clear), an accepted lookup completes one edge after acceptance as a miss with an empty mask.
- R9: Writing control bit 1 zeroes every slot, one slot per cycle. Bit 1 reads 1 for DEPTH+1 cycles and then 0. During that time `lkp_ready` is low. Bits 0 and 2 take the written value.
- R10: Control bit 2 (VLAN-aware mode) is stored and read back and does not change any lookup result.
- R11: While a search is running, `lkp_ready` is low and `lkp_valid` with a different address is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | AW | Register byte offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| lkp_valid | input | 1 | Lookup request |
| lkp_mac | input | 48 | Destination address to search |
| lkp_ready | output | 1 | Engine can accept a lookup |
| res_valid | output | 1 | One-cycle result strobe |
| res_hit | output | 1 | A matching slot was found |
| res_mcast | output | 1 | The hit slot is a multicast record |
| res_port | output | 2 | Port number of the hit slot |
| res_mask | output | NPORTS | Filtered forward mask |

## Verification
A wrong scan index or a broken compare shows as a wrong latency or the wrong winner among duplicate addresses, and it is visible on the result strobe of the same lookup. A corrupted port-state or staging register appears as a mask that disagrees with the bench's own table model on the next lookup or read-back. A wipe sequencer that stops early or runs long changes how long the clear bit stays set, and it leaves slots that still read non-zero or still match right after the wipe.

// File: rtl/mlt_pkg.sv
package mlt_pkg;
    localparam int MAC_W   = 48;
    localparam int KIND_LO = 60;
    localparam int MC_BIT  = 40;
    localparam int BLK_BIT = 65;
    localparam int PORT_LO = 66;

    localparam int OFF_CTRL = 'h00;
    localparam int OFF_TCTL = 'h04;
    localparam int OFF_WHI  = 'h08;
    localparam int OFF_WMID = 'h0C;
    localparam int OFF_WLO  = 'h10;
    localparam int OFF_PST0 = 'h14;

    typedef enum logic [1:0] {
        KIND_FREE  = 2'd0,
        KIND_ADDR  = 2'd1,
        KIND_VLAN  = 2'd2,
        KIND_VADDR = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        PST_OFF   = 2'd0,
        PST_BLOCK = 2'd1,
        PST_LEARN = 2'd2,
        PST_FWD   = 2'd3
    } pst_e;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_SCAN  = 2'd1,
        SQ_CLEAR = 2'd2
    } sq_e;
endpackage

// File: rtl/mlt_store.sv
module mlt_store #(
    parameter int DEPTH = 16,
    parameter int ENT_W = 69,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [IW-1:0]    widx_i,
    input  logic [ENT_W-1:0] wdata_i,
    input  logic [IW-1:0]    aidx_i,
    output logic [ENT_W-1:0] adata_o,
    input  logic [IW-1:0]    bidx_i,
    output logic [ENT_W-1:0] bdata_o
);
    logic [ENT_W-1:0] mem_q [DEPTH];
    logic [ENT_W-1:0] mem_d [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we_i) begin
            mem_d[widx_i] = wdata_i;
        end
    end

    assign adata_o = mem_q[aidx_i];
    assign bdata_o = mem_q[bidx_i];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '{default: '0};
        end else begin
            mem_q <= mem_d;
        end
    end
endmodule

// File: rtl/mlt_match.sv
module mlt_match import mlt_pkg::*; #(
    parameter int NPORTS = 3,
    localparam int ENT_W = PORT_LO + NPORTS
) (
    input  logic [ENT_W-1:0]  entry_i,
    input  logic [MAC_W-1:0]  mac_i,
    input  logic [NPORTS-1:0] fwd_i,
    output logic              hit_o,
    output logic              mcast_o,
    output logic [1:0]        port_o,
    output logic [NPORTS-1:0] mask_o
);
    kind_e kind;

    always_comb begin
        kind    = kind_e'(entry_i[KIND_LO +: 2]);
        hit_o   = ((kind == KIND_ADDR) || (kind == KIND_VADDR)) &&
                  (entry_i[MAC_W-1:0] == mac_i);
        mcast_o = entry_i[MC_BIT];
        port_o  = entry_i[PORT_LO +: 2];
        mask_o  = '0;
        if (mcast_o) begin
            mask_o = entry_i[PORT_LO +: NPORTS] & fwd_i;
        end else if (!entry_i[BLK_BIT]) begin
            for (int p = 0; p < NPORTS; p++) begin
                if (port_o == 2'(p)) begin
                    mask_o[p] = fwd_i[p];
                end
            end
        end
    end
endmodule

// File: rtl/mlt_seq.sv
module mlt_seq import mlt_pkg::*; #(
    parameter int DEPTH  = 16,
    parameter int NPORTS = 3,
    localparam int IW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              clr_req_i,
    input  logic              lkp_valid_i,
    input  logic [MAC_W-1:0]  lkp_mac_i,
    input  logic              m_hit_i,
    input  logic              m_mcast_i,
    input  logic [1:0]        m_port_i,
    input  logic [NPORTS-1:0] m_mask_i,
    output logic              lkp_ready_o,
    output logic [IW-1:0]     idx_o,
    output logic [MAC_W-1:0]  mac_o,
    output logic              clr_we_o,
    output logic              clearing_o,
    output logic              res_valid_o,
    output logic              res_hit_o,
    output logic              res_mcast_o,
    output logic [1:0]        res_port_o,
    output logic [NPORTS-1:0] res_mask_o
);
    localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

    typedef struct packed {
        sq_e               st;
        logic [IW-1:0]     idx;
        logic              pend;
        logic [MAC_W-1:0]  mac;
        logic              rv;
        logic              rh;
        logic              rm;
        logic [1:0]        rp;
        logic [NPORTS-1:0] rk;
    } seq_s;

    seq_s q, d;

    always_comb begin
        d        = q;
        d.rv     = 1'b0;
        clr_we_o = 1'b0;
        if (clr_req_i) begin
            d.pend = 1'b1;
        end
        case (q.st)
            SQ_IDLE: begin
                if (q.pend) begin
                    d.st   = SQ_CLEAR;
                    d.idx  = '0;
                    d.pend = 1'b0;
                end else if (lkp_valid_i) begin
                    if (!en_i) begin
                        d.rv = 1'b1;
                        d.rh = 1'b0;
                        d.rm = 1'b0;
                        d.rp = '0;
                        d.rk = '0;
                    end else begin
                        d.st  = SQ_SCAN;
                        d.idx = '0;
                        d.mac = lkp_mac_i;
                    end
                end
            end
            SQ_SCAN: begin
                if (m_hit_i) begin
                    d.st = SQ_IDLE;
                    d.rv = 1'b1;
                    d.rh = 1'b1;
                    d.rm = m_mcast_i;
                    d.rp = m_port_i;
                    d.rk = m_mask_i;
                end else if (q.idx == LAST) begin
                    d.st = SQ_IDLE;
                    d.rv = 1'b1;
                    d.rh = 1'b0;
                    d.rm = 1'b0;
                    d.rp = '0;
                    d.rk = '0;
                end else begin
                    d.idx = q.idx + 1'b1;
                end
            end
            SQ_CLEAR: begin
                clr_we_o = 1'b1;
                if (q.idx == LAST) begin
                    d.st = SQ_IDLE;
                end else begin
                    d.idx = q.idx + 1'b1;
                end
            end
            default: d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign lkp_ready_o = (q.st == SQ_IDLE) && !q.pend;
    assign idx_o       = q.idx;
    assign mac_o       = q.mac;
    assign clearing_o  = q.pend || (q.st == SQ_CLEAR);
    assign res_valid_o = q.rv;
    assign res_hit_o   = q.rh;
    assign res_mcast_o = q.rm;
    assign res_port_o  = q.rp;
    assign res_mask_o  = q.rk;

    // R5
    ucast_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && res_hit_o && !res_mcast_o) |-> $onehot0(res_mask_o));

    // R8
    off_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lkp_valid_i && lkp_ready_o && !en_i) |-> (res_valid_o && !res_hit_o));

    // R9
    clear_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(q.st == SQ_CLEAR) && (q.st == SQ_IDLE)) |-> ($past(q.idx) == LAST));
endmodule

// File: rtl/mac_lookup_table.sv
module mac_lookup_table import mlt_pkg::*; #(
    parameter int DEPTH  = 16,
    parameter int NPORTS = 3,
    parameter int AW     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     reg_addr,
    input  logic              reg_we,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              lkp_valid,
    input  logic [47:0]       lkp_mac,
    output logic              lkp_ready,
    output logic              res_valid,
    output logic              res_hit,
    output logic              res_mcast,
    output logic [1:0]        res_port,
    output logic [NPORTS-1:0] res_mask
);
    localparam int IW    = $clog2(DEPTH);
    localparam int ENT_W = PORT_LO + NPORTS;
    localparam int HI_W  = ENT_W - 64;

    typedef struct packed {
        logic                   en;
        logic                   vlan;
        logic [HI_W-1:0]        whi;
        logic [31:0]            wmid;
        logic [31:0]            wlo;
        logic [IW-1:0]          tidx;
        logic [NPORTS-1:0][1:0] ps;
    } reg_s;

    reg_s r_q, r_d;

    logic              clr_req, cpu_st, clr_we, clearing;
    logic              st_we;
    logic [IW-1:0]     st_widx, seq_idx;
    logic [ENT_W-1:0]  st_wdata, rd_a, rd_b;
    logic [MAC_W-1:0]  scan_mac;
    logic [NPORTS-1:0] fwd_set, m_mask;
    logic              m_hit, m_mcast;
    logic [1:0]        m_port;

    always_comb begin
        for (int p = 0; p < NPORTS; p++) begin
            fwd_set[p] = (r_q.ps[p] == PST_FWD);
        end
    end

    always_comb begin
        r_d     = r_q;
        clr_req = 1'b0;
        cpu_st  = 1'b0;
        if (reg_we) begin
            if (reg_addr == AW'(OFF_CTRL)) begin
                r_d.en   = reg_wdata[0];
                r_d.vlan = reg_wdata[2];
                clr_req  = reg_wdata[1];
            end
            if (reg_addr == AW'(OFF_TCTL)) begin
                r_d.tidx = reg_wdata[IW-1:0];
                if (reg_wdata[31]) begin
                    cpu_st = 1'b1;
                end else begin
                    {r_d.whi, r_d.wmid, r_d.wlo} = rd_b;
                end
            end
            if (reg_addr == AW'(OFF_WHI))  r_d.whi  = reg_wdata[HI_W-1:0];
            if (reg_addr == AW'(OFF_WMID)) r_d.wmid = reg_wdata;
            if (reg_addr == AW'(OFF_WLO))  r_d.wlo  = reg_wdata;
            for (int p = 0; p < NPORTS; p++) begin
                if (reg_addr == AW'(OFF_PST0 + 4 * p)) begin
                    r_d.ps[p] = reg_wdata[1:0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == AW'(OFF_CTRL)) reg_rdata = {29'b0, r_q.vlan, clearing, r_q.en};
        if (reg_addr == AW'(OFF_TCTL)) reg_rdata = 32'(r_q.tidx);
        if (reg_addr == AW'(OFF_WHI))  reg_rdata = 32'(r_q.whi);
        if (reg_addr == AW'(OFF_WMID)) reg_rdata = r_q.wmid;
        if (reg_addr == AW'(OFF_WLO))  reg_rdata = r_q.wlo;
        for (int p = 0; p < NPORTS; p++) begin
            if (reg_addr == AW'(OFF_PST0 + 4 * p)) begin
                reg_rdata = {30'b0, r_q.ps[p]};
            end
        end
    end

    assign st_we    = clr_we || (cpu_st && !clearing);
    assign st_widx  = clr_we ? seq_idx : reg_wdata[IW-1:0];
    assign st_wdata = clr_we ? '0 : {r_q.whi, r_q.wmid, r_q.wlo};

    mlt_store #(.DEPTH(DEPTH), .ENT_W(ENT_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (st_we),
        .widx_i  (st_widx),
        .wdata_i (st_wdata),
        .aidx_i  (seq_idx),
        .adata_o (rd_a),
        .bidx_i  (reg_wdata[IW-1:0]),
        .bdata_o (rd_b)
    );

    mlt_match #(.NPORTS(NPORTS)) u_match (
        .entry_i (rd_a),
        .mac_i   (scan_mac),
        .fwd_i   (fwd_set),
        .hit_o   (m_hit),
        .mcast_o (m_mcast),
        .port_o  (m_port),
        .mask_o  (m_mask)
    );

    mlt_seq #(.DEPTH(DEPTH), .NPORTS(NPORTS)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (r_q.en),
        .clr_req_i   (clr_req),
        .lkp_valid_i (lkp_valid),
        .lkp_mac_i   (lkp_mac),
        .m_hit_i     (m_hit),
        .m_mcast_i   (m_mcast),
        .m_port_i    (m_port),
        .m_mask_i    (m_mask),
        .lkp_ready_o (lkp_ready),
        .idx_o       (seq_idx),
        .mac_o       (scan_mac),
        .clr_we_o    (clr_we),
        .clearing_o  (clearing),
        .res_valid_o (res_valid),
        .res_hit_o   (res_hit),
        .res_mcast_o (res_mcast),
        .res_port_o  (res_port),
        .res_mask_o  (res_mask)
    );

    // R4
    miss_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> (res_mask == '0));

    // R6
    fwd_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ((res_mask & ~$past(fwd_set)) == '0));
endmodule

// File: tb/mac_lookup_table_test.sv
module mac_lookup_table_test;
    localparam int DEPTH = 16;
    localparam int NP    = 3;
    localparam int EW    = 69;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        lkp_valid = 1'b0;
    logic [47:0] lkp_mac = '0;
    logic        lkp_ready, res_valid, res_hit, res_mcast;
    logic [1:0]  res_port;
    logic [2:0]  res_mask;

    always #10 clk = ~clk;

    mac_lookup_table #(.DEPTH(DEPTH), .NPORTS(NP)) uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lkp_valid(lkp_valid),
        .lkp_mac(lkp_mac), .lkp_ready(lkp_ready), .res_valid(res_valid),
        .res_hit(res_hit), .res_mcast(res_mcast), .res_port(res_port),
        .res_mask(res_mask)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [EW-1:0] mdl [DEPTH];
    logic [1:0]    mps [NP];
    logic          men;

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input int a, input logic [31:0] v);
        @(negedge clk);
        reg_addr = 6'(a); reg_wdata = v; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input int a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = 6'(a);
        #2 v = reg_rdata;
    endtask

    task automatic set_ctrl(input logic [31:0] v);
        reg_wr('h00, v);
        men = v[0];
    endtask

    task automatic set_ps(input int p, input logic [1:0] s);
        reg_wr('h14 + 4 * p, {30'b0, s});
        mps[p] = s;
    endtask

    task automatic wr_ent(input int i, input logic [EW-1:0] e);
        reg_wr('h08, 32'(e[68:64]));
        reg_wr('h0C, e[63:32]);
        reg_wr('h10, e[31:0]);
        reg_wr('h04, 32'h8000_0000 | 32'(i));
        mdl[i] = e;
    endtask

    task automatic rd_ent(input int i, output logic [EW-1:0] e);
        logic [31:0] a, b, c;
        reg_wr('h04, 32'(i));
        reg_rd('h08, a);
        reg_rd('h0C, b);
        reg_rd('h10, c);
        e = {a[4:0], b, c};
    endtask

    function automatic logic [EW-1:0] uc_ent(input logic [47:0] mac, input logic [1:0] port,
                                             input logic blk, input logic [1:0] kind);
        logic [EW-1:0] e = '0;
        e[47:0] = mac; e[40] = 1'b0; e[61:60] = kind;
        e[63:62] = 2'd0; e[65] = blk; e[67:66] = port;
        return e;
    endfunction

    function automatic logic [EW-1:0] mc_ent(input logic [47:0] mac, input logic [2:0] mask);
        logic [EW-1:0] e = '0;
        e[47:0] = mac; e[40] = 1'b1; e[61:60] = 2'd1;
        e[63:62] = 2'd3; e[68:66] = mask;
        return e;
    endfunction

    function automatic void model(input logic [47:0] mac, output logic h, output logic m,
                                  output logic [1:0] p, output logic [2:0] k, output int lat);
        logic [2:0] f;
        h = 1'b0; m = 1'b0; p = '0; k = '0;
        lat = men ? DEPTH + 1 : 1;
        for (int q = 0; q < NP; q++) f[q] = (mps[q] == 2'd3);
        if (men) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (!h && (mdl[i][61:60] == 2'd1 || mdl[i][61:60] == 2'd3) &&
                    mdl[i][47:0] == mac) begin
                    h = 1'b1; lat = i + 2; m = mdl[i][40]; p = mdl[i][67:66];
                    if (m) k = mdl[i][68:66] & f;
                    else if (!mdl[i][65] && p < 2'd3 && f[p]) k = 3'b001 << p;
                end
            end
        end
    endfunction

    task automatic do_lookup(input logic [47:0] mac, input string tag,
                             input bit hold, input logic [47:0] decoy);
        logic eh, em;
        logic [1:0] ep;
        logic [2:0] ek;
        int el, cnt;
        model(mac, eh, em, ep, ek, el);
        @(negedge clk);
        chk({tag, " R11 ready before request"}, lkp_ready, 1);
        lkp_valid = 1'b1; lkp_mac = mac;
        @(negedge clk);
        if (hold) lkp_mac = decoy;
        else lkp_valid = 1'b0;
        if (men) chk({tag, " R11 ready low while scanning"}, lkp_ready, 0);
        cnt = 1;
        while (!res_valid && cnt < DEPTH + 8) begin
            @(negedge clk);
            cnt++;
        end
        lkp_valid = 1'b0;
        chk({tag, " latency"}, cnt, el);
        chk({tag, " hit"}, res_hit, eh);
        if (eh) chk({tag, " mcast flag"}, res_mcast, em);
        if (eh && !em) chk({tag, " port"}, res_port, ep);
        chk({tag, " mask"}, res_mask, ek);
    endtask

    logic [47:0] pool [6];

    initial begin
        #3000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [EW-1:0] e;
        int cnt;
        int unsigned seed;
        seed = $urandom(32'd20240611);
        men = 1'b0;
        for (int i = 0; i < DEPTH; i++) mdl[i] = '0;
        for (int p = 0; p < NP; p++) mps[p] = 2'd0;
        pool[0] = 48'h0200_0000_0011; pool[1] = 48'h0200_0000_0022;
        pool[2] = 48'h0300_0000_0033; pool[3] = 48'h0100_0000_0044;
        pool[4] = 48'h0200_0000_0055; pool[5] = 48'h0100_0000_0066;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        reg_rd('h00, v); chk("R1 control after reset", v, 0);
        reg_rd('h14, v); chk("R1 port0 state after reset", v, 0);
        reg_rd('h10, v); chk("R1 low word after reset", v, 0);
        chk("R1 ready after reset", lkp_ready, 1);
        rd_ent(5, e);    chk("R1 slot 5 empty", e, 0);

        // R8 disabled engine
        wr_ent(2, uc_ent(pool[0], 2'd1, 1'b0, 2'd1));
        do_lookup(pool[0], "R8 disabled", 1'b0, '0);

        // R2 table access and word order
        for (int k = 0; k < 4; k++) begin
            logic [EW-1:0] r;
            int i;
            i = 8 + k;
            r = {$urandom, $urandom, $urandom};
            r[61:60] = 2'd2;
            wr_ent(i, r);
            rd_ent(i, e);
            chk("R2 read back slot", e, r);
            reg_rd('h08, v);
            chk("R2 high word holds bits 68:64", v, 32'(r[68:64]));
        end

        // R7 port states
        set_ctrl(32'h1);
        for (int p = 0; p < NP; p++) begin
            set_ps(p, 2'(p));
            reg_rd('h14 + 4 * p, v);
            chk("R7 port state read back", v, p);
        end
        for (int p = 0; p < NP; p++) set_ps(p, 2'd3);

        // R3 / R5 unicast hit and first-match
        do_lookup(pool[0], "R3 R5 unicast slot 2", 1'b0, '0);
        wr_ent(7, uc_ent(pool[0], 2'd2, 1'b0, 2'd1));
        do_lookup(pool[0], "R3 first match wins", 1'b0, '0);
        wr_ent(0, uc_ent(pool[0], 2'd0, 1'b0, 2'd2));
        wr_ent(1, uc_ent(pool[0], 2'd0, 1'b0, 2'd0));
        do_lookup(pool[0], "R3 vlan and free kinds skipped", 1'b0, '0);
        wr_ent(3, uc_ent(pool[1], 2'd2, 1'b0, 2'd3));
        do_lookup(pool[1], "R3 vlan+address kind matches", 1'b0, '0);

        // R5 blocked, non-forwarding, nonexistent port
        wr_ent(4, uc_ent(pool[4], 2'd0, 1'b1, 2'd1));
        do_lookup(pool[4], "R5 blocked", 1'b0, '0);
        set_ps(1, 2'd2);
        do_lookup(pool[0], "R5 port learning", 1'b0, '0);
        set_ps(1, 2'd3);
        wr_ent(5, uc_ent(pool[2] & ~48'h0100_0000_0000, 2'd3, 1'b0, 2'd1));
        do_lookup(pool[2] & ~48'h0100_0000_0000, "R5 port three", 1'b0, '0);

        // R6 multicast
        wr_ent(6, mc_ent(pool[3], 3'b101));
        do_lookup(pool[3], "R6 multicast all forwarding", 1'b0, '0);
        set_ps(2, 2'd1);
        do_lookup(pool[3], "R6 multicast port2 blocking", 1'b0, '0);
        set_ps(2, 2'd3);

        // R4 miss and last slot
        do_lookup(48'h0A0B_0C0D_0E0F, "R4 miss", 1'b0, '0);
        wr_ent(15, uc_ent(48'h0200_0000_0F0F, 2'd1, 1'b0, 2'd1));
        do_lookup(48'h0200_0000_0F0F, "R3 last slot", 1'b0, '0);

        // R11 request held with other address during scan
        do_lookup(pool[1], "R11 busy ignores", 1'b1, pool[0]);

        // R10 vlan-aware bit
        set_ctrl(32'h5);
        reg_rd('h00, v); chk("R10 control read back", v, 5);
        do_lookup(pool[0], "R10 vlan-aware same result", 1'b0, '0);
        set_ctrl(32'h1);

        // random phase
        for (int n = 0; n < 40; n++) begin
            int i;
            logic [EW-1:0] r;
            i = $urandom % DEPTH;
            r = {$urandom, $urandom, $urandom};
            r[47:0] = pool[$urandom % 6];
            if ($urandom % 2) r[40] = ~r[40];
            wr_ent(i, r);
            if (n % 5 == 0) set_ps($urandom % NP, 2'($urandom));
            do_lookup(pool[$urandom % 6], "R3 R5 R6 random", 1'b0, '0);
        end

        // R9 clear
        reg_wr('h00, 32'h7);
        men = 1'b1;
        reg_addr = 6'h00;
        #2;
        chk("R9 ready low during clear", lkp_ready, 0);
        cnt = 0;
        while (reg_rdata[1] && cnt < 100) begin
            cnt++;
            @(negedge clk);
            #2;
        end
        chk("R9 clear busy cycles", cnt, DEPTH + 1);
        chk("R9 control after clear", reg_rdata, 5);
        for (int i = 0; i < DEPTH; i++) mdl[i] = '0;
        rd_ent(7, e);  chk("R9 slot 7 zero", e, 0);
        rd_ent(15, e); chk("R9 slot 15 zero", e, 0);
        do_lookup(pool[0], "R9 lookup after clear", 1'b0, '0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule